// File: doc/BRIEF.md
# LED Dimming PWM Generator with Master/Slave Sync

This block produces the common dimming waveform that gates every channel of a multi-channel LED current driver. A free-running counter clocked by the base clock (19.2 MHz nominal) spans a programmable 18-bit period, and an 8-bit duty value sets how much of that period the waveform is high, in steps of 1/256. The internal waveform is ANDed with an external PWM pin. With the duty left at full scale, the external pin alone sets the dimming.

One pin carries the period between devices. A device in master mode drives its period out as a square wave on the sync pin. A device in slave mode releases the pin, measures the spacing of the incoming rising edges in base-clock cycles, and adopts that spacing as its own period, so a set of slaves runs at the master's frequency. Period and duty are loaded through a small write port. The loaded values reach the waveform only at a period boundary, so the output never shows a runt or partial pulse.

Top module: `pwm_dim_sync`

## Requirements
- R1: In master mode the dimming output repeats every P base-clock cycles, where P is the period register loaded through wr_data_i[17:0] with wr_sel_i = 0.
- R2: A period register value below 2 (zero included) gives a period of 2 cycles and never stops the counter.
- R3: With duty register value D (wr_sel_i = 1, wr_data_i[7:0]), the internal waveform is high for the first ceil((D+1)*P/256) cycles of each period and low for the rest. D = 255 keeps it high for the whole period.
- R4: After reset the period register is 768, the duty register is 255 and the mode is master. The counter starts at the beginning of a period, so dim_o follows ext_pwm_i from the first cycle.
- R5: dim_o is the internal waveform ANDed with ext_pwm_i. While ext_pwm_i is low, dim_o is low whatever the duty value.
- R6: A write to the period or duty register does not alter the period in progress. The new value governs the waveform from the next period boundary.
- R7: In master mode sync_oe_o is high and sync_o is high for the first floor(P/2) cycles of each period, so it rises once at every period start.
- R8: In slave mode (wr_sel_i = 2 with wr_data_i[0] = 0; a 1 selects master) sync_oe_o and sync_o are low. sync_i passes through a 2-stage synchronizer. Once two rising edges have been seen, the spacing between the last two rising edges becomes the period at the next boundary. Until then the period register is used.
- R9: A write with wr_sel_i = 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target register: 0 period, 1 duty, 2 mode, 3 none |
| wr_data_i | input | 18 | Write data |
| sync_i | input | 1 | Sync clock from the pin (slave mode) |
| sync_o | output | 1 | Sync clock to the pin (master mode) |
| sync_oe_o | output | 1 | Output enable for the sync pin |
| ext_pwm_i | input | 1 | External PWM gate |
| dim_o | output | 1 | Dimming output to the channel drivers |

## Verification
A wrong counter or active period shows up as a misplaced edge on dim_o or sync_o within one period, because both outputs are decoded from the same count. A wrong duty threshold moves the falling edge of dim_o within the first period after the faulty load. An early adoption of a new setting moves an edge inside the period that was running when the write arrived. A faulty slave measurement shows up one boundary after the second sync edge, as a period of the wrong length. The bench compares every output on every cycle against a behavioural model, so any divergence is reported in the cycle where it first appears.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;
  localparam int unsigned PER_W  = 18;
  localparam int unsigned DUTY_W = 8;

  typedef enum logic [1:0] {
    SEL_PER  = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_dim_pkg::*;
#(
  parameter int unsigned PW      = PER_W,
  parameter int unsigned DW      = DUTY_W,
  parameter int unsigned PER_RST = 768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  cfg_sel_e      wr_sel_i,
  input  logic [PW-1:0] wr_data_i,
  output logic [PW-1:0] per_o,
  output logic [DW-1:0] duty_o,
  output logic          master_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o    <= PW'(PER_RST);
      duty_o   <= '1;
      master_o <= 1'b1;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_PER:  per_o    <= wr_data_i;
        SEL_DUTY: duty_o   <= wr_data_i[DW-1:0];
        SEL_MODE: master_o <= wr_data_i[0];
        default:  ;
      endcase
    end
  end

  assert_rsvd_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_sel_i == SEL_NONE) |->
      ($stable(per_o) && $stable(duty_o) && $stable(master_o)));
endmodule

// File: rtl/pwm_sync_meas.sv
module pwm_sync_meas #(
  parameter int unsigned PW     = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  output logic [PW-1:0] meas_o,
  output logic          meas_vld_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q, seen_q, rise;
  logic [PW-1:0]     run_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b0;
      seen_q     <= 1'b0;
      run_q      <= '0;
      meas_o     <= '0;
      meas_vld_o <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      if (rise) begin
        seen_q <= 1'b1;
        run_q  <= PW'(1);
        if (seen_q) begin
          meas_o     <= run_q;
          meas_vld_o <= 1'b1;
        end
      end else if (run_q != '1) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_meas_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_vld_o |-> (meas_o != '0));
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int unsigned PW      = 18,
  parameter int unsigned DW      = 8,
  parameter int unsigned PER_RST = 768,
  parameter int unsigned MIN_PER = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] per_src_i,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o,
  output logic          half_o
);
  localparam int unsigned PRW = PW + DW + 1;

  logic [PW-1:0]  cnt_q, per_q, thr_q, per_eff;
  logic [PRW-1:0] prod;
  logic           wrap;

  assign per_eff = (per_src_i < PW'(MIN_PER)) ? PW'(MIN_PER) : per_src_i;
  // ceil((duty+1)*per/2^DW)
  assign prod = (PRW'(duty_i) + PRW'(1)) * PRW'(per_eff) + PRW'((1 << DW) - 1);
  assign wrap = (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= PW'(PER_RST);
      thr_q <= PW'(PER_RST);
    end else if (wrap) begin
      cnt_q <= '0;
      per_q <= per_eff;
      thr_q <= prod[DW +: PW];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm_o  = cnt_q < thr_q;
  assign half_o = cnt_q < (per_q >> 1);

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);
  assert_min_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q >= PW'(MIN_PER));
  assert_thr_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q <= per_q && thr_q != '0);
  assert_load_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(per_q) && $stable(thr_q)) |-> cnt_q == '0);
endmodule

// File: rtl/pwm_dim_sync.sv
module pwm_dim_sync
  import pwm_dim_pkg::*;
#(
  parameter int unsigned PER_RST     = 768,
  parameter int unsigned MIN_PER     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [PER_W-1:0] wr_data_i,
  input  logic             sync_i,
  output logic             sync_o,
  output logic             sync_oe_o,
  input  logic             ext_pwm_i,
  output logic             dim_o
);
  logic [PER_W-1:0]  per_reg, meas, per_src;
  logic [DUTY_W-1:0] duty_reg;
  logic              master, meas_vld, pwm_int, half;

  pwm_cfg_regs #(.PW(PER_W), .DW(DUTY_W), .PER_RST(PER_RST)) i_regs (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_sel_i (cfg_sel_e'(wr_sel_i)),
    .wr_data_i,
    .per_o    (per_reg),
    .duty_o   (duty_reg),
    .master_o (master)
  );

  pwm_sync_meas #(.PW(PER_W), .STAGES(SYNC_STAGES)) i_meas (
    .clk_i, .rst_ni, .sync_i,
    .meas_o     (meas),
    .meas_vld_o (meas_vld)
  );

  assign per_src = (!master && meas_vld) ? meas : per_reg;

  pwm_period_core #(.PW(PER_W), .DW(DUTY_W), .PER_RST(PER_RST), .MIN_PER(MIN_PER)) i_core (
    .clk_i, .rst_ni,
    .per_src_i (per_src),
    .duty_i    (duty_reg),
    .pwm_o     (pwm_int),
    .half_o    (half)
  );

  assign sync_oe_o = master;
  assign sync_o    = master & half;
  assign dim_o     = pwm_int & ext_pwm_i;

  assert_slave_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master |-> (!sync_oe_o && !sync_o));
  assert_ext_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dim_o |-> ext_pwm_i);
endmodule

// File: tb/test_pwm_dim_sync.sv
module test_pwm_dim_sync;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, sync_in = 0, ext = 1;
  logic [1:0]  wr_sel = 0;
  logic [17:0] wr_data = 0;
  logic        sync_out, sync_oe, dim;

  int vectors = 0, fails = 0;
  string tag = "R4";

  always #4 clk = ~clk;

  pwm_dim_sync i_pwm_dim_sync (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sync_i(sync_in), .sync_o(sync_out),
    .sync_oe_o(sync_oe), .ext_pwm_i(ext), .dim_o(dim)
  );

  // behavioural reference
  int m_psh = 768, m_dsh = 255, m_mst = 1, m_cnt = 0, m_per = 768, m_thr = 768;
  int s0 = 0, s1 = 0, sprev = 0, m_seen = 0, m_run = 0, m_mval = 0, m_mvld = 0;

  always @(posedge clk) if (rst_n) begin
    int src, r;
    src = (!m_mst && m_mvld) ? m_mval : m_psh;
    if (src < 2) src = 2;
    if (m_cnt == m_per - 1) begin
      m_cnt = 0; m_per = src; m_thr = ((m_dsh + 1) * src + 255) / 256;
    end else m_cnt++;
    r = s1 && !sprev;
    sprev = s1; s1 = s0; s0 = sync_in;
    if (r) begin
      if (m_seen) begin m_mval = m_run; m_mvld = 1; end
      m_seen = 1; m_run = 1;
    end else if (m_run != 262143) m_run++;
    if (wr_en) case (wr_sel)
      0: m_psh = wr_data;
      1: m_dsh = wr_data[7:0];
      2: m_mst = wr_data[0];
      default: ;
    endcase
  end

  task automatic check(string t, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(tag, dim, (m_cnt < m_thr) && ext, "dim_o");
    check(tag, sync_oe, m_mst, "sync_oe_o");
    check(tag, sync_out, m_mst && (m_cnt < m_per / 2), "sync_o");
  end

  // sync pin generator for slave tests
  int sync_per = 0, sync_ph = 0;
  always @(posedge clk) begin
    #1;
    if (sync_per > 0) begin
      sync_in = (sync_ph < sync_per / 2);
      sync_ph = (sync_ph + 1 == sync_per) ? 0 : sync_ph + 1;
    end else sync_in = 0;
  end

  task automatic wr(int sel, int data);
    @(posedge clk); #1;
    wr_en = 1; wr_sel = 2'(sel); wr_data = 18'(data);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic wait_rise(ref logic sig);
    logic p;
    p = sig;
    forever begin
      @(negedge clk);
      if (sig && !p) break;
      p = sig;
    end
  endtask

  // cycles from one rise of dim to the next, and high cycles in it
  task automatic meas_dim(output int per, output int hi);
    logic p;
    wait_rise(dim);
    per = 1; hi = 1; p = 1;
    forever begin
      @(negedge clk);
      if (dim && !p) break;
      per++; if (dim) hi++;
      p = dim;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int per, hi, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R4", dim, 1, "reset dim_o");
    check("R4", sync_oe, 1, "reset sync_oe_o");
    check("R4", sync_out, 1, "reset sync_o");

    tag = "R7";
    wait_rise(sync_out);
    n = 1;
    forever begin @(negedge clk); if (!sync_out) break; n++; end
    check("R7", n, 384, "sync_o high time");
    wait_rise(sync_out);
    n = 0;
    repeat (768) begin @(negedge clk); if (sync_out) n++; end
    check("R7", n, 384, "sync_o high per period");

    tag = "R1";
    wr(0, 100); wr(1, 63);
    repeat (2000) @(posedge clk);
    meas_dim(per, hi);
    check("R1", per, 100, "period");
    check("R3", hi, 25, "high time D=63 P=100");

    tag = "R6";
    wait_rise(dim);
    wr(1, 127);
    @(negedge clk);
    n = 0;
    repeat (30) begin @(negedge clk); if (dim) n++; end
    check("R6", n, 22, "old duty held in running period");
    meas_dim(per, hi);
    check("R6", hi, 50, "new duty after boundary");

    tag = "R3";
    wr(0, 512); wr(1, 0);
    repeat (1200) @(posedge clk);
    meas_dim(per, hi);
    check("R3", per, 512, "period 512");
    check("R3", hi, 2, "high time D=0");

    tag = "R9";
    wr(3, 5);
    repeat (1200) @(posedge clk);
    meas_dim(per, hi);
    check("R9", per, 512, "period after sel 3");
    check("R9", hi, 2, "duty after sel 3");

    tag = "R2";
    wr(0, 0);
    repeat (1200) @(posedge clk);
    meas_dim(per, hi);
    check("R2", per, 2, "period value 0");
    wr(0, 1);
    repeat (20) @(posedge clk);
    meas_dim(per, hi);
    check("R2", per, 2, "period value 1");

    tag = "R5";
    wr(0, 64); wr(1, 200);
    repeat (200) @(posedge clk);
    #1 ext = 0;
    n = 0;
    repeat (300) begin @(negedge clk); if (dim) n++; end
    check("R5", n, 0, "dim_o high cycles with ext low");
    @(posedge clk); #1 ext = 1;
    repeat (200) @(posedge clk);
    #1 ext = 0;
    @(negedge clk);
    check("R5", dim, 0, "dim_o with ext low at full duty area");
    @(posedge clk); #1 ext = 1;

    tag = "R8";
    wr(0, 512); wr(1, 127);
    repeat (600) @(posedge clk);
    sync_per = 300;
    wr(2, 0);
    @(negedge clk);
    check("R8", sync_oe, 0, "slave sync_oe_o");
    repeat (2000) @(posedge clk);
    meas_dim(per, hi);
    check("R8", per, 300, "slave tracked period");
    check("R8", hi, 150, "slave high time");
    sync_per = 450;
    repeat (3000) @(posedge clk);
    meas_dim(per, hi);
    check("R8", per, 450, "slave retracked period");

    tag = "R7";
    wr(2, 1);
    sync_per = 0;
    repeat (1200) @(posedge clk);
    meas_dim(per, hi);
    check("R7", per, 512, "master again uses register");
    @(negedge clk);
    check("R7", sync_oe, 1, "master sync_oe_o");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule